// File: doc/BRIEF.md
# Wavefront Instruction Issue Arbiter

This block picks, once per clock, which instructions go to the execution pipes of one SIMD unit. The SIMD keeps ten wavefront slots. Each slot offers only the oldest instruction it has not yet issued. For that instruction the slot gives a valid bit, a 3-bit class code and a ready flag, which its own dependency tracking drives. Each of the seven execution classes has a ready input from its pipe. In one cycle the arbiter may issue at most one instruction per class. Every instruction issued in the same cycle must come from a different slot.

The arbiter matches classes to slots. It visits the classes in a fixed rank order, starting with vector ALU. For each class it takes the first eligible slot at or after a rotating start pointer, and it skips any slot that an earlier class has already taken. After each cycle with at least one grant, the pointer moves one slot forward and wraps at ten. Results are registered. A per-slot one-hot grant goes back to the slots so each can advance its head. A per-class valid plus a slot index goes to the pipes. Both appear one cycle after the inputs they depend on are sampled.

Class codes: 0 branch, 1 scalar ALU/memory, 2 vector ALU, 3 vector memory, 4 local data share, 5 global data share/export, 6 special, 7 illegal.

Top module: `issue_arbiter`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are zero after that edge, whatever the candidates are. The start pointer returns to slot 0.
- R2: When `issue_valid[c]` is high, the slot given in field c of `issue_slot` (bits c*4+3..c*4) held, in the previous cycle, a valid head of class code c with its slot ready set.
- R3: No slot is granted twice in a cycle. The number of bits set in `slot_grant` equals the number set in `issue_valid`.
- R4: A slot whose `slot_ready` bit is low receives no grant for that cycle.
- R5: A head carrying class code 7 is never granted.
- R6: A class whose `class_ready` bit is low issues nothing for that cycle.
- R7: Among the eligible slots of a class, the arbiter grants the first one found by counting upward from the start pointer, modulo 10.
- R8: The start pointer moves forward by one, modulo 10, after every cycle that produced a grant. It holds after a cycle with no grant.
- R9: Grants appear one clock after their candidates are sampled. They do not appear in the same cycle.
- R10: If a class is ready and some valid, ready head of that class exists, that class issues in the next cycle. No eligible pair is left idle.
- R11: When all seven classes each have an eligible head in distinct slots, all seven issue in the same cycle.
- R12: `slot_grant[s]` is high exactly when some `issue_valid[c]` is high with slot index s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 10 | Slot has a head instruction |
| cand_class | input | 30 | 3-bit class code per slot; slot s uses bits s*3+2..s*3 |
| slot_ready | input | 10 | Slot's head has its operands ready |
| class_ready | input | 7 | Execution pipe of each class can accept an instruction |
| slot_grant | output | 10 | Registered one-hot-per-slot grant back to the slots |
| issue_valid | output | 7 | Registered per-class issue strobe |
| issue_slot | output | 28 | 4-bit granted slot index per class; class c uses bits c*4+3..c*4 |

## Verification
The properties assume that every input is a known value at each rising edge. They also assume that a slot's class code means something only while its valid bit is high. No property depends on how the slots advance after a grant. The bench drives fresh values at each falling edge, so every sampled input is defined. It covers arbitrary class codes, including the illegal code. It varies both ready vectors freely and never relies on the slots retiring anything. This lets the bench's own pointer model follow the design from reset onward.

// File: rtl/issue_arb_pkg.sv
package issue_arb_pkg;

  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_BRANCH  = 3'd0,
    CLS_SCALAR  = 3'd1,
    CLS_VALU    = 3'd2,
    CLS_VMEM    = 3'd3,
    CLS_LDS     = 3'd4,
    CLS_GDS     = 3'd5,
    CLS_SPECIAL = 3'd6,
    CLS_ILLEGAL = 3'd7
  } iclass_e;

  // Rank r of the class walk: vector ALU first, wrapping round to branch/scalar.
  function automatic int rank_class(input int rank, input int ncls);
    return (rank + int'(CLS_VALU)) % ncls;
  endfunction

endpackage

// File: rtl/arb_eligibility.sv
module arb_eligibility #(
  parameter int NUM_SLOTS   = 10,
  parameter int NUM_CLASSES = 7,
  parameter int CLS_W       = 3
) (
  input  logic [NUM_SLOTS-1:0]             cand_valid,
  input  logic [NUM_SLOTS*CLS_W-1:0]       cand_class,
  input  logic [NUM_SLOTS-1:0]             slot_ready,
  input  logic [NUM_CLASSES-1:0]           class_ready,
  output logic [NUM_CLASSES*NUM_SLOTS-1:0] req
);

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      // Code 7 never matches: c only spans the legal classes.
      assign req[c*NUM_SLOTS+s] = cand_valid[s] & slot_ready[s] & class_ready[c] &
                                  (cand_class[s*CLS_W +: CLS_W] == CLS_W'(c));
    end
  end

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N     = 10,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found  = 1'b0;
    onehot = '0;
    idx    = '0;
    for (int off = 0; off < N; off++) begin
      int p;
      p = int'(start) + off;
      if (p >= N) p = p - N;
      if (!found && req[p]) begin
        found     = 1'b1;
        onehot[p] = 1'b1;
        idx       = IDX_W'(p);
      end
    end
  end

endmodule

// File: rtl/arb_ptr.sv
module arb_ptr #(
  parameter int N     = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/issue_arbiter.sv
module issue_arbiter #(
  parameter int NUM_SLOTS   = 10,
  parameter int NUM_CLASSES = 7,
  parameter int CLS_W       = 3,
  parameter int IDX_W       = $clog2(NUM_SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_SLOTS-1:0]         cand_valid,
  input  logic [NUM_SLOTS*CLS_W-1:0]   cand_class,
  input  logic [NUM_SLOTS-1:0]         slot_ready,
  input  logic [NUM_CLASSES-1:0]       class_ready,
  output logic [NUM_SLOTS-1:0]         slot_grant,
  output logic [NUM_CLASSES-1:0]       issue_valid,
  output logic [NUM_CLASSES*IDX_W-1:0] issue_slot
);

  import issue_arb_pkg::*;

  logic [NUM_CLASSES*NUM_SLOTS-1:0] req;
  logic [IDX_W-1:0]                 ptr;
  logic [NUM_SLOTS-1:0]             taken [NUM_CLASSES+1];
  logic [NUM_CLASSES-1:0]           nxt_valid;
  logic [NUM_CLASSES*IDX_W-1:0]     nxt_slot;
  logic                             any_grant;

  arb_eligibility #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_CLASSES(NUM_CLASSES), .CLS_W(CLS_W)
  ) u_elig (
    .cand_valid (cand_valid),
    .cand_class (cand_class),
    .slot_ready (slot_ready),
    .class_ready(class_ready),
    .req        (req)
  );

  assign taken[0] = '0;

  // Class walk in rank order; each rank masks out slots won by earlier ranks.
  for (genvar r = 0; r < NUM_CLASSES; r++) begin : g_rank
    localparam int C = rank_class(r, NUM_CLASSES);
    logic [NUM_SLOTS-1:0] oh;
    logic                 hit;
    logic [IDX_W-1:0]     sel;

    arb_rr_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
      .req   (req[C*NUM_SLOTS +: NUM_SLOTS] & ~taken[r]),
      .start (ptr),
      .found (hit),
      .onehot(oh),
      .idx   (sel)
    );

    assign taken[r+1]                = taken[r] | oh;
    assign nxt_valid[C]              = hit;
    assign nxt_slot[C*IDX_W +: IDX_W] = sel;
  end

  assign any_grant = |taken[NUM_CLASSES];

  arb_ptr #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .advance(any_grant),
    .ptr    (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_grant  <= '0;
      issue_valid <= '0;
      issue_slot  <= '0;
    end else begin
      slot_grant  <= taken[NUM_CLASSES];
      issue_valid <= nxt_valid;
      issue_slot  <= nxt_slot;
    end
  end

endmodule

// File: rtl/issue_arbiter_chk.sv
module issue_arbiter_chk #(
  parameter int NUM_SLOTS   = 10,
  parameter int NUM_CLASSES = 7,
  parameter int CLS_W       = 3,
  parameter int IDX_W       = $clog2(NUM_SLOTS)
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_SLOTS-1:0]         cand_valid,
  input logic [NUM_SLOTS*CLS_W-1:0]   cand_class,
  input logic [NUM_SLOTS-1:0]         slot_ready,
  input logic [NUM_CLASSES-1:0]       class_ready,
  input logic [NUM_SLOTS-1:0]         slot_grant,
  input logic [NUM_CLASSES-1:0]       issue_valid,
  input logic [NUM_CLASSES*IDX_W-1:0] issue_slot
);

  logic                       armed;
  logic [NUM_SLOTS-1:0]       p_valid;
  logic [NUM_SLOTS*CLS_W-1:0] p_class;
  logic [NUM_SLOTS-1:0]       p_sready;
  logic [NUM_CLASSES-1:0]     p_cready;

  always_ff @(posedge clk) begin
    armed    <= !rst;
    p_valid  <= cand_valid;
    p_class  <= cand_class;
    p_sready <= slot_ready;
    p_cready <= class_ready;
  end

  function automatic logic head_ok(input logic [IDX_W-1:0] s, input int c);
    if (int'(s) >= NUM_SLOTS) return 1'b0;
    return p_valid[s] && p_sready[s] && (p_class[int'(s)*CLS_W +: CLS_W] == CLS_W'(c));
  endfunction

  function automatic logic grant_bit(input logic [IDX_W-1:0] s);
    if (int'(s) >= NUM_SLOTS) return 1'b0;
    return slot_grant[s];
  endfunction

  assert_reset_R1: assert property (@(posedge clk) $past(rst) |-> (slot_grant == '0 && issue_valid == '0));

  assert_one_per_slot_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_grant) == $countones(issue_valid));

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_c
    logic [IDX_W-1:0] sl;
    logic             want;
    assign sl = issue_slot[c*IDX_W +: IDX_W];
    always_comb begin
      want = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++)
        if (p_valid[s] && p_sready[s] && p_class[s*CLS_W +: CLS_W] == CLS_W'(c)) want = 1'b1;
    end

    assert_class_match_R2: assert property (@(posedge clk) disable iff (rst)
      armed && issue_valid[c] |-> head_ok(sl, c));
    assert_pipe_stall_R6: assert property (@(posedge clk) disable iff (rst)
      armed && !p_cready[c] |-> !issue_valid[c]);
    assert_no_idle_R10: assert property (@(posedge clk) disable iff (rst)
      armed && p_cready[c] && want |-> issue_valid[c]);
    assert_grant_link_R12: assert property (@(posedge clk) disable iff (rst)
      issue_valid[c] |-> grant_bit(sl));
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_s
    assert_legal_code_R5: assert property (@(posedge clk) disable iff (rst)
      armed && slot_grant[s] |-> p_class[s*CLS_W +: CLS_W] != {CLS_W{1'b1}});
    assert_slot_stall_R4: assert property (@(posedge clk) disable iff (rst)
      armed && !p_sready[s] |-> !slot_grant[s]);
  end

endmodule

bind issue_arbiter issue_arbiter_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_CLASSES(NUM_CLASSES), .CLS_W(CLS_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/issue_arbiter_tb.sv
`timescale 1ns/1ps
module issue_arbiter_tb;

  localparam int NS = 10;
  localparam int NC = 7;
  localparam int CW = 3;
  localparam int IW = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NS-1:0]     cand_valid = '0;
  logic [NS*CW-1:0]  cand_class = '0;
  logic [NS-1:0]     slot_ready = '0;
  logic [NC-1:0]     class_ready = '0;
  logic [NS-1:0]     slot_grant;
  logic [NC-1:0]     issue_valid;
  logic [NC*IW-1:0]  issue_slot;

  logic [NS-1:0]     exp_grant;
  logic [NC-1:0]     exp_valid;
  logic [NC*IW-1:0]  exp_slot;
  int                mptr = 0;
  int                checks = 0;
  int                errors = 0;

  always #4 clk = ~clk;

  issue_arbiter #(.NUM_SLOTS(NS), .NUM_CLASSES(NC), .CLS_W(CW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_class(cand_class),
    .slot_ready(slot_ready), .class_ready(class_ready),
    .slot_grant(slot_grant), .issue_valid(issue_valid), .issue_slot(issue_slot)
  );

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  // Each class independently takes the first eligible slot counting up from mptr.
  task automatic calc_expected();
    exp_grant = '0; exp_valid = '0; exp_slot = '0;
    for (int c = 0; c < NC; c++) begin
      for (int off = 0; off < NS; off++) begin
        int s;
        s = (mptr + off) % NS;
        if (!exp_valid[c] && class_ready[c] && cand_valid[s] && slot_ready[s] &&
            cand_class[s*CW +: CW] == CW'(c) && !exp_grant[s]) begin
          exp_valid[c] = 1'b1;
          exp_grant[s] = 1'b1;
          exp_slot[c*IW +: IW] = IW'(s);
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (slot_grant !== exp_grant || issue_valid !== exp_valid || issue_slot !== exp_slot) begin
      errors++;
      $display("FAIL %s: actual grant=%h valid=%h slots=%h expected grant=%h valid=%h slots=%h",
               tag, slot_grant, issue_valid, issue_slot, exp_grant, exp_valid, exp_slot);
    end
  endtask

  task automatic step(input string tag);
    calc_expected();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    if (exp_valid != '0) mptr = (mptr + 1) % NS;
  endtask

  task automatic set_all(input logic [2:0] code);
    for (int s = 0; s < NS; s++) cand_class[s*CW +: CW] = code;
  endtask

  initial begin
    // R1: reset dominates live candidates
    @(negedge clk);
    cand_valid = '1; slot_ready = '1; class_ready = '1; set_all(3'd2);
    repeat (3) @(negedge clk);
    checks++;
    if (slot_grant !== '0 || issue_valid !== '0) begin
      errors++;
      $display("FAIL R1: actual grant=%h valid=%h expected 0", slot_grant, issue_valid);
    end
    rst = 1'b0;
    cand_valid = '0;
    mptr = 0;

    // R9: nothing before the edge, grant after it
    @(negedge clk);
    cand_valid = 10'b0000001000; set_all(3'd2);
    #1;
    checks++;
    if (issue_valid !== '0) begin
      errors++;
      $display("FAIL R9: actual valid=%h before edge expected 0", issue_valid);
    end
    step("R9");

    // R11: one head of each class in distinct slots
    for (int s = 0; s < NS; s++) cand_class[s*CW +: CW] = CW'(s % 7);
    cand_valid = 10'b0001111111;
    step("R11");
    checks++;
    if ($countones(issue_valid) != 7) begin
      errors++;
      $display("FAIL R11: actual issues=%0d expected 7", $countones(issue_valid));
    end

    // R5: illegal code everywhere
    set_all(3'd7); cand_valid = '1;
    step("R5");

    // R8: idle cycle holds pointer, then full rotation on one class
    cand_valid = '0;
    step("R8");
    set_all(3'd2); cand_valid = '1;
    for (int k = 0; k < 12; k++) step("R7 R8");

    // R6: vector ALU pipe stalled while other classes compete
    for (int s = 0; s < NS; s++) cand_class[s*CW +: CW] = CW'(s % 4);
    class_ready = 7'b1111011;
    step("R6");
    class_ready = '1;

    // R4: half the slots not ready
    slot_ready = 10'b0101010101;
    step("R4");
    slot_ready = '1;

    // R2 R3 R7 R10 R12: random sweep
    for (int k = 0; k < 4000; k++) begin
      cand_valid  = NS'($urandom);
      for (int s = 0; s < NS; s++) cand_class[s*CW +: CW] = CW'($urandom % 8);
      slot_ready  = NS'($urandom) | NS'($urandom);
      class_ready = NC'($urandom) | NC'($urandom);
      step("R2 R3 R10");
      checks++;
      if ($countones(slot_grant) != $countones(issue_valid)) begin
        errors++;
        $display("FAIL R12: actual grants=%0d issues=%0d expected equal",
                 $countones(slot_grant), $countones(issue_valid));
      end
    end

    finish_run();
  end

endmodule